// File: doc/BRIEF.md
# Run-Length Cluster Packer

The packer takes one sample word per valid cycle and builds a compressed capture image in an external memory. Each valid cycle advances a 16-bit tick counter. A sample is recorded as an event only when its level pattern differs from the sample before it, so long stretches of constant input cost nothing. Recorded events are gathered into clusters of eight words. The first word is a timestamp, and up to seven events follow it at consecutive ticks, starting from that timestamp.

A cluster is written in one beat over a full-cluster-wide write port. The write goes to a word address whose upper bits pick a row and whose lower 9 bits pick the word within a 512-word row. The write position keeps advancing and wraps after the last row. The packer also forces an event at least once every 65536 ticks, so that a reader can always unwrap the 16-bit timestamps.

Top module: `rle_cluster_packer`

## Requirements
- R1: While rst_ni is low and after it is released, wr_en_o is 0, wr_pos_o is 0 and round_o is 0 until the first write.
- R2: The first valid sample after reset is always recorded and opens a cluster. Its tick is 0, which becomes that cluster's timestamp.
- R3: A valid sample equal to the previous valid sample is not recorded, unless R8 applies. Cycles with valid_i low neither record anything nor advance the tick.
- R4: A changed sample whose tick is exactly one more than the last event of the open cluster is appended to that cluster, provided the cluster holds fewer than seven events.
- R5: A cluster is written when its seventh event arrives. In wr_data_o, bits [15:0] carry the timestamp and bits [16k+15:16k] carry event k for k = 1..7, in tick order.
- R6: A changed sample that is not consecutive to the open cluster's last event, or that arrives when no cluster is open, opens a new cluster with its own tick as the timestamp. A cluster that was open is written at that moment.
- R7: In a cluster written before it holds seven events, every unused event slot repeats the cluster's last event.
- R8: A valid sample whose tick is 65535 after the timestamp of the most recently opened cluster is recorded even when unchanged, and it opens a new cluster.
- R9: Each write goes to wr_pos_o, which then advances by 8 words. The address is {row, word}, with the word index in the low 9 bits. After the last row the position wraps to 0, and round_o goes to 1 and stays set.
- R10: The write caused by a sample appears on the write port in the cycle after the clock edge that sampled it, as a single-cycle wr_en_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Sample present this cycle; advances the tick |
| sample_i | input | WORD_W | Sample levels |
| wr_en_o | output | 1 | Write strobe for one cluster |
| wr_addr_o | output | ROW_BITS+COL_BITS | Word address of the cluster's first word |
| wr_data_o | output | (EVENTS+1)*WORD_W | Timestamp word then event words |
| wr_pos_o | output | ROW_BITS+COL_BITS | Next write position |
| round_o | output | 1 | Set once the position has wrapped |

## Verification
A wrong cluster count or a lost open flag shows up at the next write. The timestamp word, the padding or the number of events will differ from what the sample sequence dictates, and this becomes visible one cycle after the sample that closes the cluster. A wrong tick or a broken force rule surfaces only when a later cluster is written. A broken position counter is caught on every write through the address and its step of 8. A small row count lets the wrap and the sticky round flag be reached within a few hundred writes, and a long constant run reaches the forced event.

// File: rtl/rle_pack_pkg.sv
package rle_pack_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_APPEND = 2'd1,
    ACT_START  = 2'd2
  } act_e;
endpackage

// File: rtl/rle_change_det.sv
module rle_change_det #(
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] sample_i,
  input  logic [WORD_W-1:0] clu_ts_i,
  output logic [WORD_W-1:0] tick_o,
  output logic              store_o
);
  logic [WORD_W-1:0] tick_q, prev_q, age;
  logic              seen_q, force_evt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      prev_q <= '0;
      seen_q <= 1'b0;
    end else if (valid_i) begin
      tick_q <= tick_q + 1'b1;
      prev_q <= sample_i;
      seen_q <= 1'b1;
    end
  end

  // forced event keeps timestamp gaps below one full rollover
  assign age       = tick_q - clu_ts_i;
  assign force_evt = &age;
  assign tick_o    = tick_q;
  assign store_o   = valid_i && (!seen_q || (sample_i != prev_q) || force_evt);
endmodule

// File: rtl/rle_cluster_buf.sv
module rle_cluster_buf #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned EVENTS = 7,
  localparam int unsigned CNT_W = $clog2(EVENTS + 1),
  localparam int unsigned SLOTS = 1 << CNT_W,
  localparam int unsigned BUS_W = (EVENTS + 1) * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CNT_W-1:0]  widx_i,
  input  logic [WORD_W-1:0] sample_i,
  input  logic [WORD_W-1:0] ts_i,
  input  logic [CNT_W-1:0]  n_i,
  input  logic              add_i,
  output logic [BUS_W-1:0]  data_o
);
  logic [WORD_W-1:0] ev_q [SLOTS];
  logic [WORD_W-1:0] last_ev;
  logic [CNT_W-1:0]  last_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < SLOTS; k++) ev_q[k] <= '0;
    end else if (we_i) begin
      ev_q[widx_i] <= sample_i;
    end
  end

  assign last_idx = n_i - CNT_W'(1);
  assign last_ev  = add_i ? sample_i : ev_q[last_idx];
  assign data_o[WORD_W-1:0] = ts_i;

  for (genvar j = 0; j < EVENTS; j++) begin : g_slot
    always_comb begin
      if (CNT_W'(j) < n_i)
        data_o[(j+1)*WORD_W +: WORD_W] = ev_q[j];
      else if (add_i && (CNT_W'(j) == n_i))
        data_o[(j+1)*WORD_W +: WORD_W] = sample_i;
      else
        data_o[(j+1)*WORD_W +: WORD_W] = last_ev;
    end
  end
endmodule

// File: rtl/rle_addr_gen.sv
module rle_addr_gen #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned STEP   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] pos_o,
  output logic              round_o
);
  logic [ADDR_W-1:0] pos_q;
  logic [ADDR_W:0]   sum;
  logic              round_q;

  assign sum = {1'b0, pos_q} + (ADDR_W+1)'(STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q   <= '0;
      round_q <= 1'b0;
    end else if (adv_i) begin
      pos_q <= sum[ADDR_W-1:0];
      if (sum[ADDR_W]) round_q <= 1'b1;
    end
  end

  assign pos_o   = pos_q;
  assign round_o = round_q;
endmodule

// File: rtl/rle_cluster_packer.sv
module rle_cluster_packer
  import rle_pack_pkg::*;
#(
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned EVENTS   = 7,
  parameter int unsigned ROW_BITS = 15,
  parameter int unsigned COL_BITS = 9,
  localparam int unsigned ADDR_W   = ROW_BITS + COL_BITS,
  localparam int unsigned CL_WORDS = EVENTS + 1,
  localparam int unsigned CNT_W    = $clog2(EVENTS + 1),
  localparam int unsigned BUS_W    = CL_WORDS * WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] sample_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BUS_W-1:0]  wr_data_o,
  output logic [ADDR_W-1:0] wr_pos_o,
  output logic              round_o
);
  logic [WORD_W-1:0] tick, clu_ts_q, next_ts;
  logic [CNT_W-1:0]  cnt_q;
  logic              open_q, store, consec, append, full, start, emit;
  logic [BUS_W-1:0]  clu_data;
  logic [ADDR_W-1:0] pos;
  act_e              act;

  rle_change_det #(.WORD_W(WORD_W)) u_det (
    .clk_i, .rst_ni, .valid_i, .sample_i,
    .clu_ts_i(clu_ts_q), .tick_o(tick), .store_o(store)
  );

  assign next_ts = clu_ts_q + WORD_W'(cnt_q);
  assign consec  = open_q && (tick == next_ts);
  assign append  = store && consec;
  assign full    = append && (cnt_q == CNT_W'(EVENTS - 1));
  assign start   = store && !consec;
  assign emit    = full || (start && open_q);
  assign act     = start ? ACT_START : (append ? ACT_APPEND : ACT_NONE);

  rle_cluster_buf #(.WORD_W(WORD_W), .EVENTS(EVENTS)) u_buf (
    .clk_i, .rst_ni,
    .we_i    (start || append),
    .widx_i  (start ? '0 : cnt_q),
    .sample_i,
    .ts_i    (clu_ts_q),
    .n_i     (cnt_q),
    .add_i   (full),
    .data_o  (clu_data)
  );

  rle_addr_gen #(.ADDR_W(ADDR_W), .STEP(CL_WORDS)) u_addr (
    .clk_i, .rst_ni, .adv_i(emit), .pos_o(pos), .round_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q    <= 1'b0;
      cnt_q     <= '0;
      clu_ts_q  <= '0;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= emit;
      if (emit) begin
        wr_addr_o <= pos;
        wr_data_o <= clu_data;
      end
      unique case (act)
        ACT_START: begin
          open_q   <= 1'b1;
          cnt_q    <= CNT_W'(1);
          clu_ts_q <= tick;
        end
        ACT_APPEND: begin
          if (full) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign wr_pos_o = pos;
endmodule

// File: rtl/rle_cluster_packer_chk.sv
module rle_cluster_packer_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned STEP   = 8,
  localparam int unsigned LOW_W = $clog2(STEP)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              wr_en_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [ADDR_W-1:0] wr_pos_o,
  input logic              round_o
);
  p_aligned_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_addr_o[LOW_W-1:0] == '0));

  p_pos_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (wr_pos_o == ADDR_W'(wr_addr_o + ADDR_W'(STEP))));

  p_pos_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> $stable(wr_pos_o));

  p_round_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    round_o |=> round_o);

  p_round_on_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(round_o) |-> (wr_en_o && (wr_pos_o == '0)));

  p_write_after_sample_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> $past(valid_i));
endmodule

bind rle_cluster_packer rle_cluster_packer_chk #(.ADDR_W(ADDR_W), .STEP(CL_WORDS)) u_chk (
  .clk_i, .rst_ni, .valid_i, .wr_en_o, .wr_addr_o, .wr_pos_o, .round_o
);

// File: tb/rle_cluster_packer_test.sv
`timescale 1ns/1ps
module rle_cluster_packer_test;
  localparam int unsigned RB = 2;
  localparam int unsigned AW = RB + 9;
  localparam int unsigned BW = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [15:0] sample = '0;
  logic wr_en, round;
  logic [AW-1:0] wr_addr, wr_pos;
  logic [BW-1:0] wr_data;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  // model state
  logic        m_seen = 1'b0;
  logic [15:0] m_prev = '0, m_tick = '0, m_clts = '0, m_last = '0;
  logic [15:0] m_ev [7];
  int          m_n = 0;
  int          m_writes = 0;
  logic        e_en = 1'b0, e_round = 1'b0;
  logic [BW-1:0] e_data = '0;
  logic [AW-1:0] e_addr = '0, e_pos = '0;

  always #2.5 clk = ~clk;

  rle_cluster_packer #(.ROW_BITS(RB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .sample_i(sample),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .wr_pos_o(wr_pos), .round_o(round)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run hung (req %s) got timeout expected completion", cur_req);
    summary();
  end

  task automatic emit();
    e_data[15:0] = m_clts;
    for (int k = 0; k < 7; k++)
      e_data[16*(k+1) +: 16] = (k < m_n) ? m_ev[k] : m_ev[m_n-1];
    e_addr = AW'(m_writes * 8);
    m_writes++;
    e_pos = AW'(m_writes * 8);
    if (m_writes * 8 >= (1 << AW)) e_round = 1'b1;
    e_en = 1'b1;
  endtask

  task automatic model(input logic v, input logic [15:0] s);
    logic [15:0] t, gap, nxt;
    logic chg;
    e_en = 1'b0;
    if (v) begin
      t   = m_tick;
      gap = t - m_clts;
      nxt = m_last + 16'd1;
      chg = !m_seen || (s != m_prev) || (gap == 16'hFFFF);
      m_seen = 1'b1;
      m_prev = s;
      m_tick = m_tick + 16'd1;
      if (chg) begin
        if (m_n > 0 && t == nxt) begin
          m_ev[m_n] = s; m_n++; m_last = t;
          if (m_n == 7) begin emit(); m_n = 0; end
        end else begin
          if (m_n > 0) emit();
          m_ev[0] = s; m_n = 1; m_clts = t; m_last = t;
        end
      end
    end
  endtask

  task automatic check_cycle();
    checks++;
    if (wr_en !== e_en || (e_en && (wr_data !== e_data || wr_addr !== e_addr)) ||
        wr_pos !== e_pos || round !== e_round) begin
      fails++;
      $display("FAIL %s: got en=%0b addr=%h pos=%h rnd=%0b data=%h expected en=%0b addr=%h pos=%h rnd=%0b data=%h",
               cur_req, wr_en, wr_addr, wr_pos, round, wr_data, e_en, e_addr, e_pos, e_round, e_data);
    end
  endtask

  task automatic step(input logic v, input logic [15:0] s);
    @(negedge clk);
    valid = v; sample = s;
    model(v, s);
    @(posedge clk); #1;
    check_cycle();
  endtask

  initial begin
    for (int k = 0; k < 7; k++) m_ev[k] = '0;
    repeat (3) @(posedge clk);
    #1;
    cur_req = "R1 reset";
    check_cycle();
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check_cycle();

    // R2 first sample recorded at tick 0; R3 repeats dropped; R6 R7 gap closes padded cluster
    cur_req = "R2 R3 R6 R7";
    step(1, 16'h1234);
    step(1, 16'h1234);
    step(0, 16'h5555);
    step(1, 16'h1234);
    step(1, 16'h1235);

    // R4 R5 consecutive changes fill a cluster, write one cycle later (R10)
    cur_req = "R4 R5 R10";
    for (int i = 1; i < 8; i++) step(1, 16'h1235 + 16'(i));
    step(1, 16'h1235 + 16'd7);
    step(1, 16'hAAAA);

    // R6 R7 short consecutive run then a gap
    cur_req = "R6 R7";
    step(1, 16'hAAAB);
    step(1, 16'hAAAB);
    step(1, 16'h0001);

    // R9 wrap: one write per change every second tick
    cur_req = "R9 wrap";
    for (int i = 0; i < 600; i++) step(1, ((i / 2) % 2 == 1) ? 16'hF0F0 : 16'h0F0F);
    checks++;
    if (round !== 1'b1) begin
      fails++;
      $display("FAIL R9: round got %0b expected 1", round);
    end

    // mixed sweep with gaps and short runs
    cur_req = "R3 R4 R6 R7 sweep";
    begin
      logic [15:0] lf = 16'hACE1;
      for (int i = 0; i < 3000; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step(lf[0] | lf[5], {14'h0, lf[3:2]});
      end
    end

    // R8 forced event after a long constant run
    cur_req = "R8 force";
    step(1, 16'hBEEF);
    for (int i = 0; i < 65600; i++) step(1, 16'hBEEF);
    step(1, 16'hC0DE);
    step(1, 16'hC0DE);
    step(1, 16'h0000);

    summary();
  end
endmodule